// File: doc/BRIEF.md
# Interrupt Routing Table Controller

This block collects interrupt requests from 32 sources and steers them to 32 hardware thread outputs. Each source owns two programmable words. The first word is a bit mask that names the destination threads. The second word holds an enable bit and a 6-bit vector number. The block remembers which sources are pending. For every thread, it presents the lowest-numbered pending source that is enabled and routed to that thread. A write-one-to-clear acknowledge register retires pending sources.

Sources 1 to 8 carry timer events and respond to rising edges. All other sources, including source 0, are level inputs.

A separate register write sends a software inter-processor interrupt to one thread. That thread is named by a core field and a thread-in-core field, and the write can carry a non-maskable flag. Software reaches the block through a plain register read/write port.

Top module: `irq_route_ctrl`

## Requirements
- R1: During reset and in the first cycle after reset, every thread request, vector and NMI output is 0 and the read data is 0. All routing words reset to 0.
- R2: A write at offset 0x40+n stores the destination mask of source n. A write at offset 0x80+n stores its control word. A read returns the stored 32-bit word unchanged on reg_rdata in the cycle after reg_rd. Reads at offsets 0x04, 0x06 and unmapped offsets return 0.
- R3: Sources 1 to 8 become pending on a 0-to-1 input transition. They stay pending after the input falls, until acknowledged. An input held high after the acknowledge does not make them pending again.
- R4: Every other source becomes pending while its input is high. An acknowledge clears it for one cycle. It becomes pending again in the next cycle if the input is still high. It stays pending after the input falls, until acknowledged.
- R5: Thread t requests when some source s is pending, has bit 31 of its control word set and has bit t of its mask set. Several threads can take the same source at once. The vector is control bits 5:0, NMI is 0, and the vector reads 0 when nothing is requested. The outputs change in the cycle after the clock edge that sampled the cause.
- R6: Clearing control bit 31 masks the source at once but keeps its pending state. Setting the bit again delivers the source again.
- R7: When several qualifying sources become pending together, thread t receives the lowest-numbered one.
- R8: Once a thread shows a source, the output stays on that source while the source remains pending and enabled, even if a lower-numbered source becomes pending meanwhile.
- R9: Writing offset 0x06 clears the pending state of every source whose data bit is 1. Bits that are 0 leave their source unchanged.
- R10: A write at offset 0x04 raises a request on exactly one thread for the single following cycle. The thread number is {data[22:20], data[17:16]}. The vector is data[5:0] and the NMI flag is data[8]. This request overrides that thread's routed output for that cycle, and the routed output returns afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| src_in | input | 32 | Interrupt source inputs |
| thr_req | output | 32 | Per-thread interrupt request |
| thr_vec | output | 192 | Per-thread 6-bit vector; thread t uses bits 6t+5:6t |
| thr_nmi | output | 32 | Per-thread non-maskable flag |

## Verification
The hardest state to reach from the ports is one where a thread is already showing a higher-numbered source when a lower-numbered source becomes pending. Reaching it takes two cycles. The stimulus raises the higher source first and lets it appear on the output. It then raises the lower source, so the hold rule and the priority rule disagree, and it acknowledges the shown source to watch the handover. Two other collisions are driven on purpose. In the first, an inter-processor interrupt lands on a thread that already carries a routed source. In the second, a timer input is acknowledged while it is still held high.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int IDX_W   = 6;
    localparam int VEC_W   = 6;
    localparam int CORE_W  = 3;
    localparam int TID_W   = 2;
    localparam int THR_W   = CORE_W + TID_W;
    localparam int NUM_THR = 1 << THR_W;

    localparam logic [ADDR_W-1:0] OFS_IPI = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ACK = 8'h06;
    localparam logic [ADDR_W-IDX_W-1:0] PAGE_MASK = 2'b01;
    localparam logic [ADDR_W-IDX_W-1:0] PAGE_CTRL = 2'b10;

    localparam int EN_BIT       = 31;
    localparam int IPI_NMI_BIT  = 8;
    localparam int IPI_TID_LSB  = 16;
    localparam int IPI_CORE_LSB = 20;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IPI,
        SEL_ACK,
        SEL_MASK,
        SEL_CTRL
    } reg_sel_e;

    typedef struct packed {
        logic             fire;
        logic             nmi;
        logic [THR_W-1:0] thr;
        logic [VEC_W-1:0] vec;
    } ipi_cmd_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a, input int nsrc);
        reg_sel_e r;
        r = SEL_NONE;
        if (a == OFS_IPI) begin
            r = SEL_IPI;
        end else if (a == OFS_ACK) begin
            r = SEL_ACK;
        end else if (int'(a[IDX_W-1:0]) < nsrc) begin
            if (a[ADDR_W-1:IDX_W] == PAGE_MASK) begin
                r = SEL_MASK;
            end else if (a[ADDR_W-1:IDX_W] == PAGE_CTRL) begin
                r = SEL_CTRL;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               reg_wr,
    input  logic                               reg_rd,
    input  logic [ADDR_W-1:0]                  reg_addr,
    input  logic [DATA_W-1:0]                  reg_wdata,
    output logic [DATA_W-1:0]                  reg_rdata,
    output logic [NUM_SRC-1:0][NUM_THR-1:0]    route_mask,
    output logic [NUM_SRC-1:0]                 route_en,
    output logic [NUM_SRC-1:0][VEC_W-1:0]      src_vec,
    output logic [NUM_SRC-1:0]                 ack_vec,
    output ipi_cmd_t                           ipi
);

    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    reg_sel_e                           sel;
    logic [SRC_W-1:0]                   idx;
    logic [NUM_SRC-1:0][NUM_THR-1:0]    mask_q;
    logic [NUM_SRC-1:0][DATA_W-1:0]     ctrl_q;
    logic [DATA_W-1:0]                  rdata_q;
    ipi_cmd_t                           ipi_q;

    assign sel = decode_addr(reg_addr, NUM_SRC);
    assign idx = reg_addr[SRC_W-1:0];

    // routing table storage
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            ctrl_q <= '0;
        end else if (reg_wr) begin
            if (sel == SEL_MASK) mask_q[idx] <= reg_wdata[NUM_THR-1:0];
            if (sel == SEL_CTRL) ctrl_q[idx] <= reg_wdata;
        end
    end

    // registered readback
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            rdata_q <= '0;
            case (sel)
                SEL_MASK: rdata_q[NUM_THR-1:0] <= mask_q[idx];
                SEL_CTRL: rdata_q <= ctrl_q[idx];
                default:  rdata_q <= '0;
            endcase
        end
    end

    // software interrupt command, live for one cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            ipi_q <= '0;
        end else begin
            ipi_q.fire <= reg_wr && (sel == SEL_IPI);
            if (reg_wr && (sel == SEL_IPI)) begin
                ipi_q.nmi <= reg_wdata[IPI_NMI_BIT];
                ipi_q.thr <= {reg_wdata[IPI_CORE_LSB +: CORE_W], reg_wdata[IPI_TID_LSB +: TID_W]};
                ipi_q.vec <= reg_wdata[VEC_W-1:0];
            end
        end
    end

    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            route_en[s] = ctrl_q[s][EN_BIT];
            src_vec[s]  = ctrl_q[s][VEC_W-1:0];
        end
    end

    assign ack_vec    = (reg_wr && (sel == SEL_ACK)) ? reg_wdata[NUM_SRC-1:0] : '0;
    assign route_mask = mask_q;
    assign reg_rdata  = rdata_q;
    assign ipi        = ipi_q;

endmodule

// File: rtl/irq_route_pending.sv
module irq_route_pending
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int EDGE_LO = 1,
    parameter int EDGE_HI = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] ack_vec,
    output logic [NUM_SRC-1:0] pend
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic pend_q;
        if ((g >= EDGE_LO) && (g <= EDGE_HI)) begin : g_edge
            logic prev_q;
            // a fresh rise wins over a same-cycle acknowledge
            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= 1'b0;
                    pend_q <= 1'b0;
                end else begin
                    prev_q <= src_in[g];
                    pend_q <= (src_in[g] & ~prev_q) | (pend_q & ~ack_vec[g]);
                end
            end
        end else begin : g_level
            // acknowledge wins; a held input re-arms one cycle later
            always_ff @(posedge clk) begin
                if (rst) begin
                    pend_q <= 1'b0;
                end else begin
                    pend_q <= (pend_q | src_in[g]) & ~ack_vec[g];
                end
            end
        end
        assign pend[g] = pend_q;
    end

endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_SRC-1:0]                 pend,
    input  logic [NUM_SRC-1:0]                 route_en,
    input  logic [NUM_SRC-1:0][NUM_THR-1:0]    route_mask,
    input  logic [NUM_SRC-1:0][VEC_W-1:0]      src_vec,
    input  ipi_cmd_t                           ipi,
    output logic [NUM_THR-1:0]                 thr_req,
    output logic [NUM_THR-1:0][VEC_W-1:0]      thr_vec,
    output logic [NUM_THR-1:0]                 thr_nmi
);

    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        logic [NUM_SRC-1:0] act;
        logic [SRC_W-1:0]   low_idx;
        logic [SRC_W-1:0]   cur_q;
        logic [SRC_W-1:0]   pick;
        logic               cur_vld_q;
        logic               any;
        logic               keep;
        logic               ipi_hit;

        always_comb begin
            for (int s = 0; s < NUM_SRC; s++) begin
                act[s] = pend[s] & route_en[s] & route_mask[s][t];
            end
        end

        always_comb begin
            low_idx = '0;
            for (int s = NUM_SRC - 1; s >= 0; s--) begin
                if (act[s]) low_idx = SRC_W'(s);
            end
        end

        assign any  = |act;
        assign keep = cur_vld_q & act[cur_q];
        assign pick = keep ? cur_q : low_idx;

        // in-service source held per thread
        always_ff @(posedge clk) begin
            if (rst) begin
                cur_vld_q <= 1'b0;
                cur_q     <= '0;
            end else begin
                cur_vld_q <= any;
                cur_q     <= pick;
            end
        end

        assign ipi_hit    = ipi.fire && (ipi.thr == THR_W'(t));
        assign thr_req[t] = ipi_hit | any;
        assign thr_vec[t] = ipi_hit ? ipi.vec : (any ? src_vec[pick] : '0);
        assign thr_nmi[t] = ipi_hit & ipi.nmi;
    end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int EDGE_LO = 1,
    parameter int EDGE_HI = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    input  logic [NUM_SRC-1:0]         src_in,
    output logic [NUM_THR-1:0]         thr_req,
    output logic [NUM_THR*VEC_W-1:0]   thr_vec,
    output logic [NUM_THR-1:0]         thr_nmi
);

    logic [NUM_SRC-1:0][NUM_THR-1:0]   route_mask;
    logic [NUM_SRC-1:0]                route_en;
    logic [NUM_SRC-1:0][VEC_W-1:0]     src_vec;
    logic [NUM_SRC-1:0]                ack_vec;
    logic [NUM_SRC-1:0]                pend;
    logic [NUM_THR-1:0][VEC_W-1:0]     thr_vec_a;
    ipi_cmd_t                          ipi;

    irq_route_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .route_mask (route_mask),
        .route_en   (route_en),
        .src_vec    (src_vec),
        .ack_vec    (ack_vec),
        .ipi        (ipi)
    );

    irq_route_pending #(.NUM_SRC(NUM_SRC), .EDGE_LO(EDGE_LO), .EDGE_HI(EDGE_HI)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .src_in  (src_in),
        .ack_vec (ack_vec),
        .pend    (pend)
    );

    irq_route_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .pend       (pend),
        .route_en   (route_en),
        .route_mask (route_mask),
        .src_vec    (src_vec),
        .ipi        (ipi),
        .thr_req    (thr_req),
        .thr_vec    (thr_vec_a),
        .thr_nmi    (thr_nmi)
    );

    assign thr_vec = thr_vec_a;

endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int EDGE_LO = 1,
    parameter int EDGE_HI = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       reg_wr,
    input logic                       reg_rd,
    input logic [ADDR_W-1:0]          reg_addr,
    input logic [DATA_W-1:0]          reg_wdata,
    input logic [DATA_W-1:0]          reg_rdata,
    input logic [NUM_THR-1:0]         thr_req,
    input logic [NUM_THR*VEC_W-1:0]   thr_vec,
    input logic [NUM_THR-1:0]         thr_nmi,
    input logic [NUM_SRC-1:0]         pend
);

    logic ack_wr;
    assign ack_wr = reg_wr && (reg_addr == OFS_ACK);

    // R1: outputs quiet right after a reset cycle
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (thr_req == '0 && thr_nmi == '0 && reg_rdata == '0));

    // R2: the software interrupt offset reads as zero
    assert_ipi_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == OFS_IPI) |=> (reg_rdata == '0));

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_chk
        // R3 / R9: pending only leaves through an acknowledge bit
        assert_pend_sticky_R3: assert property (@(posedge clk) disable iff (rst)
            (pend[s] && !(ack_wr && reg_wdata[s])) |=> pend[s]);
        if (!((s >= EDGE_LO) && (s <= EDGE_HI))) begin : g_lvl
            // R4: acknowledge of a level source always clears it for a cycle
            assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
                (ack_wr && reg_wdata[s]) |=> !pend[s]);
        end
    end

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr_chk
        // R10: the NMI flag never appears without a request
        assert_nmi_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
            thr_nmi[t] |-> thr_req[t]);
        // R8: with no register writes, a shown request holds its vector
        assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
            (thr_req[t] && !reg_wr && !$past(reg_wr)) |=>
                (thr_req[t] && $stable(thr_vec[t*VEC_W +: VEC_W])));
    end

endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .EDGE_LO (EDGE_LO),
    .EDGE_HI (EDGE_HI)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .thr_req   (thr_req),
    .thr_vec   (thr_vec),
    .thr_nmi   (thr_nmi),
    .pend      (pend)
);

// File: tb/irq_route_ctrl_bench.sv
`timescale 1ns/1ps
module irq_route_ctrl_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr = 1'b0;
    logic         reg_rd = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [31:0]  src_in = '0;
    logic [31:0]  thr_req;
    logic [191:0] thr_vec;
    logic [31:0]  thr_nmi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0: thread outputs, 1: read data
        int          idx;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    event  sample_ev;

    bit       m_req [32];
    bit [5:0] m_vec [32];
    bit       m_nmi [32];

    always #5 clk = ~clk;

    irq_route_ctrl u_irq_route_ctrl (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_in    (src_in),
        .thr_req   (thr_req),
        .thr_vec   (thr_vec),
        .thr_nmi   (thr_nmi)
    );

    // monitor: pops expected items and compares against live outputs
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = exp_q.pop_front();
                if (it.kind == 0)
                    act = {24'b0, thr_nmi[it.idx], thr_req[it.idx], thr_vec[it.idx*6 +: 6]};
                else
                    act = reg_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: item %0d actual=%h expected=%h", it.tag, it.idx, act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic cfg(input int s, input logic [31:0] mask, input logic [31:0] ctrl);
        wr(8'(8'h40 + s), mask);
        wr(8'(8'h80 + s), ctrl);
    endtask

    task automatic set_thr(input int t, input bit [5:0] v, input bit n);
        m_req[t] = 1'b1; m_vec[t] = v; m_nmi[t] = n;
    endtask

    task automatic clr_thr(input int t);
        m_req[t] = 1'b0; m_vec[t] = '0; m_nmi[t] = 1'b0;
    endtask

    task automatic check_threads(input string tag);
        for (int t = 0; t < 32; t++) begin
            item_t it;
            it.kind = 0; it.idx = t; it.tag = tag;
            it.exp  = {24'b0, m_nmi[t], m_req[t], m_vec[t]};
            exp_q.push_back(it);
        end
        -> sample_ev;
        #1;
    endtask

    task automatic check_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_rd = 1'b1; reg_addr = a;
        tick();
        reg_rd = 1'b0;
        it.kind = 1; it.idx = int'(a); it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < 32; t++) clr_thr(t);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R1 reset state
        check_threads("R1 reset outputs");
        check_rd(8'h40, 32'h0, "R1 mask reset");
        check_rd(8'h80, 32'h0, "R1 ctrl reset");

        // R2 readback
        wr(8'h43, 32'hA5A5_0001);
        wr(8'h83, 32'h4000_0047);
        wr(8'h9F, 32'hFFFF_FFC0);
        check_rd(8'h43, 32'hA5A5_0001, "R2 mask readback");
        check_rd(8'h83, 32'h4000_0047, "R2 ctrl readback");
        check_rd(8'h9F, 32'hFFFF_FFC0, "R2 ctrl readback last");
        check_rd(8'h04, 32'h0, "R2 ipi offset reads zero");
        check_rd(8'h06, 32'h0, "R2 ack offset reads zero");
        check_rd(8'h20, 32'h0, "R2 unmapped reads zero");
        check_threads("R5 nothing pending");

        // R5 / R4 level source to two threads
        cfg(10, (32'h1 << 2) | (32'h1 << 9), 32'h8000_0015);
        src_in[10] = 1'b1;
        tick();
        set_thr(2, 6'd21, 0); set_thr(9, 6'd21, 0);
        check_threads("R5 routed to two threads");
        wr(8'h06, 32'h1 << 10);
        clr_thr(2); clr_thr(9);
        check_threads("R4 ack clears level");
        tick();
        set_thr(2, 6'd21, 0); set_thr(9, 6'd21, 0);
        check_threads("R4 level re-pends");
        src_in[10] = 1'b0;
        tick();
        check_threads("R4 latched after input falls");
        wr(8'h06, 32'h1 << 10);
        clr_thr(2); clr_thr(9);
        check_threads("R9 ack clears");
        tick();
        check_threads("R4 stays clear");

        // R3 edge source
        cfg(4, 32'h1, 32'h8000_0009);
        src_in[4] = 1'b1;
        tick();
        set_thr(0, 6'd9, 0);
        check_threads("R3 edge latch");
        src_in[4] = 1'b0;
        tick();
        check_threads("R3 held after fall");
        src_in[4] = 1'b1;
        tick();
        check_threads("R3 second rise while pending");
        wr(8'h06, 32'h1 << 4);
        clr_thr(0);
        check_threads("R3 ack with input high");
        tick();
        check_threads("R3 steady high no re-pend");
        src_in[4] = 1'b0;
        tick();
        src_in[4] = 1'b1;
        tick();
        set_thr(0, 6'd9, 0);
        check_threads("R3 new edge");
        wr(8'h06, 32'h1 << 4);
        clr_thr(0);
        src_in[4] = 1'b0;
        tick();
        check_threads("R3 cleared");

        // R6 enable masking
        cfg(20, 32'h1 << 5, 32'h0000_0030);
        src_in[20] = 1'b1;
        tick();
        check_threads("R6 disabled gives no request");
        wr(8'h94, 32'h8000_0030);
        set_thr(5, 6'd48, 0);
        check_threads("R6 enabled delivers");
        wr(8'h94, 32'h0000_0030);
        clr_thr(5);
        check_threads("R6 masked");
        src_in[20] = 1'b0;
        tick();
        wr(8'h94, 32'h8000_0030);
        set_thr(5, 6'd48, 0);
        check_threads("R6 pending kept while masked");
        wr(8'h06, 32'h1 << 20);
        clr_thr(5);
        check_threads("R9 ack after mask test");

        // R7 priority
        cfg(12, 32'h1 << 1, 32'h8000_000C);
        cfg(7, 32'h1 << 1, 32'h8000_0007);
        src_in[12] = 1'b1; src_in[7] = 1'b1;
        tick();
        set_thr(1, 6'd7, 0);
        check_threads("R7 lowest first");
        wr(8'h06, 32'h1 << 7);
        set_thr(1, 6'd12, 0);
        check_threads("R7 next source");
        src_in[12] = 1'b0; src_in[7] = 1'b0;
        tick();
        wr(8'h06, 32'h1 << 12);
        clr_thr(1);
        check_threads("R7 all cleared");

        // R8 hold
        src_in[12] = 1'b1;
        tick();
        set_thr(1, 6'd12, 0);
        check_threads("R8 first shown");
        src_in[7] = 1'b1;
        tick();
        check_threads("R8 held despite lower source");
        src_in[12] = 1'b0; src_in[7] = 1'b0;
        tick();
        check_threads("R8 still held");
        wr(8'h06, 32'h1 << 12);
        set_thr(1, 6'd7, 0);
        check_threads("R8 released to lower");

        // R9 zero bits
        wr(8'h06, 32'h0);
        check_threads("R9 zero write no effect");
        wr(8'h06, 32'h1 << 13);
        check_threads("R9 other bit no effect");
        wr(8'h06, 32'h1 << 7);
        clr_thr(1);
        check_threads("R9 targeted clear");

        // R10 inter-processor interrupts
        src_in[12] = 1'b1;
        tick();
        src_in[12] = 1'b0;
        set_thr(1, 6'd12, 0);
        check_threads("R10 setup routed");
        wr(8'h04, (32'd0 << 20) | (32'd1 << 16) | 32'd5);
        set_thr(1, 6'd5, 0);
        check_threads("R10 ipi overrides routed");
        tick();
        set_thr(1, 6'd12, 0);
        check_threads("R10 routed returns");
        wr(8'h04, (32'd2 << 20) | (32'd3 << 16) | (32'd1 << 8) | 32'h2A);
        set_thr(11, 6'h2A, 1);
        check_threads("R10 nmi to thread 11");
        tick();
        clr_thr(11);
        check_threads("R10 single cycle");
        wr(8'h04, (32'd7 << 20) | (32'd3 << 16) | (32'd1 << 8) | 32'h3F);
        set_thr(31, 6'h3F, 1);
        check_threads("R10 top thread");
        tick();
        clr_thr(31);
        wr(8'h06, 32'h1 << 12);
        clr_thr(1);
        check_threads("R10 final clear");

        done = 1;
        summary();
        $finish;
    end

endmodule